// File: doc/BRIEF.md
# ADC Channel List Scan Sequencer

This block sits between a bus register decoder and the front end of a multiplexed analog-to-digital converter. Software programs a list of scan entries through a small register window. Each entry gives a channel number, a two-bit gain code and a sample/hold control bit. After the list is sealed, every conversion trigger launches one conversion on the next entry. The list is read in a cycle, returning to its first entry after its last.

Conversion results come back from the converter and are stored in a result FIFO owned by the block. Software pops results from the head of the FIFO. A packed status word reports the FIFO fill level as active-low flags, an A/D ready bit and sticky error bits. The error bits cover a result dropped on a full FIFO, a trigger arriving during a conversion, a trigger arriving with no list running, and a write past the end of the list. Two control bits select unipolar conversion and differential inputs for the whole list.

The list only accepts entries while loading is open. Loading opens on a three-write handshake to the mode register: 2, then 0, then 1. It closes on a write of 0, and scanning starts there.

Top module: `scanq_top`

## Requirements
- R1: After reset no list is running, fe_start is 0, and status reads 0x181: FIFO not full (bit 8 high), not half full (bit 7 high), empty (bit 6 low), A/D ready (bit 0 high), and every error bit clear.
- R2: Register addresses are 0 control, 1 mode, 2 list and 3 FIFO reset. Loading opens only on the mode writes 2, 0, 1 in that order. A wrong value during the handshake returns to idle, and list writes made while loading is not open have no effect.
- R3: A list word holds the channel in bits 7:0, the range code in bits 9:8 and the sample/hold bit in bit 10. One cycle after an accepted trigger, fe_start pulses for one cycle and fe_chan, fe_range and fe_sh show the entry.
- R4: A mode write of 0 while loading is open closes the list and starts scanning at entry 0. Successive accepted triggers step through the entries in load order and return to entry 0 after the last one.
- R5: The list holds 256 entries. A list write beyond that count is dropped and sets the sticky list-overflow flag (status bit 9). That flag clears when loading opens again.
- R6: Each adc_done pulse pushes adc_data into the FIFO. fifo_q shows the oldest stored result, and a fifo_rd pulse removes it, so results leave in arrival order.
- R7: The FIFO holds 1024 results. Status bit 7 is low when 512 or more are stored, and bit 8 is low when 1024 are stored.
- R8: A push onto a full FIFO drops the result and sets sticky status bit 1. Any write to the FIFO reset address, whatever the data, empties the FIFO and clears status bits 1, 2 and 3.
- R9: Between an accepted trigger and the next adc_done, status bit 0 is low. A trigger in that window sets sticky status bit 2, produces no fe_start and does not advance the list.
- R10: A trigger while no list is scanning produces no fe_start and sets sticky status bit 3.
- R11: Control bit 7 drives fe_unipolar and control bit 6 drives fe_diff, for all entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| conv_trig | input | 1 | Conversion trigger pulse |
| adc_done | input | 1 | Conversion result valid |
| adc_data | input | 16 | Conversion result |
| fifo_rd | input | 1 | Pop the FIFO head |
| fifo_q | output | 16 | FIFO head result |
| status | output | 10 | Packed status word |
| fe_start | output | 1 | Start-of-conversion pulse |
| fe_chan | output | 8 | Channel for the conversion |
| fe_range | output | 2 | Gain code for the conversion |
| fe_sh | output | 1 | Sample/hold control bit |
| fe_unipolar | output | 1 | Unipolar mode |
| fe_diff | output | 1 | Differential input mode |

## Verification
A wrong list pointer shows up on fe_chan at the very next accepted trigger. A wrap or overflow fault shows up only after the list has been exhausted, so the bench runs past the end of both a short list and a full 256-entry list. FIFO pointer or count faults show up in the status word one cycle after the push or pop that crosses a threshold, and in the order of popped data. A busy flag that fails to clear shows up as a missing fe_start on the next trigger.

// File: rtl/scanq_pkg.sv
package scanq_pkg;

    localparam int unsigned SQ_WORD_W   = 16;
    localparam int unsigned SQ_CHAN_W   = 8;
    localparam int unsigned SQ_RNG_W    = 2;
    localparam int unsigned SQ_RNG_LSB  = 8;
    localparam int unsigned SQ_SH_BIT   = 10;
    localparam int unsigned SQ_STAT_W   = 10;

    localparam int unsigned CTRL_UNI_BIT  = 7;
    localparam int unsigned CTRL_DIFF_BIT = 6;

    localparam int unsigned ST_LIST_OVF = 9;
    localparam int unsigned ST_NFULL    = 8;
    localparam int unsigned ST_NHALF    = 7;
    localparam int unsigned ST_NEMPTY   = 6;
    localparam int unsigned ST_BURST    = 3;
    localparam int unsigned ST_OSPEED   = 2;
    localparam int unsigned ST_OVERRUN  = 1;
    localparam int unsigned ST_READY    = 0;

    localparam logic [SQ_WORD_W-1:0] MODE_ARM_A = 16'd2;
    localparam logic [SQ_WORD_W-1:0] MODE_ARM_B = 16'd0;
    localparam logic [SQ_WORD_W-1:0] MODE_OPEN  = 16'd1;
    localparam logic [SQ_WORD_W-1:0] MODE_CLOSE = 16'd0;

    typedef enum logic [1:0] {
        ADDR_CTRL     = 2'd0,
        ADDR_MODE     = 2'd1,
        ADDR_LIST     = 2'd2,
        ADDR_FIFO_CLR = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_ARM1,
        LD_ARM2,
        LD_OPEN,
        LD_SCAN
    } ld_state_e;

    typedef struct packed {
        logic                 sh;
        logic [SQ_RNG_W-1:0]  rng;
        logic [SQ_CHAN_W-1:0] chan;
    } entry_t;

    function automatic entry_t unpack_entry(input logic [SQ_SH_BIT:0] w);
        entry_t e;
        e.chan = w[SQ_CHAN_W-1:0];
        e.rng  = w[SQ_RNG_LSB +: SQ_RNG_W];
        e.sh   = w[SQ_SH_BIT];
        return e;
    endfunction

endpackage

// File: rtl/scanq_list.sv
module scanq_list
    import scanq_pkg::*;
#(
    parameter int unsigned DEPTH = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_we,
    input  logic [SQ_WORD_W-1:0] mode_val,
    input  logic                 list_we,
    input  entry_t               list_ent,
    input  logic                 step,
    output entry_t               cur,
    output logic                 running,
    output logic                 ovf
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    entry_t          mem [DEPTH];
    ld_state_e       st;
    logic [CW-1:0]   cnt;
    logic [AW-1:0]   ptr;
    logic            room;
    logic            at_last;

    assign room    = cnt < CW'(DEPTH);
    assign at_last = (CW'(ptr) + CW'(1)) == cnt;
    assign running = (st == LD_SCAN);
    assign cur     = mem[ptr];

    always_ff @(posedge clk) begin
        if (list_we && st == LD_OPEN && room)
            mem[cnt[AW-1:0]] <= list_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= LD_IDLE;
            cnt <= '0;
            ptr <= '0;
            ovf <= 1'b0;
        end else if (mode_we) begin
            if (mode_val == MODE_ARM_A) begin
                st <= LD_ARM1;
            end else begin
                unique case (st)
                    LD_ARM1: st <= (mode_val == MODE_ARM_B) ? LD_ARM2 : LD_IDLE;
                    LD_ARM2: begin
                        if (mode_val == MODE_OPEN) begin
                            st  <= LD_OPEN;
                            cnt <= '0;
                            ptr <= '0;
                            ovf <= 1'b0;
                        end else begin
                            st <= LD_IDLE;
                        end
                    end
                    LD_OPEN: begin
                        if (mode_val == MODE_CLOSE) begin
                            st  <= (cnt != '0) ? LD_SCAN : LD_IDLE;
                            ptr <= '0;
                        end
                    end
                    default: st <= st;
                endcase
            end
        end else if (list_we && st == LD_OPEN) begin
            if (room) cnt <= cnt + CW'(1);
            else      ovf <= 1'b1;
        end else if (step && st == LD_SCAN) begin
            ptr <= at_last ? '0 : ptr + AW'(1);
        end
    end

    assert_ovf_on_extra_write_R5: assert property (@(posedge clk) disable iff (rst)
        (list_we && !mode_we && st == LD_OPEN && !room) |=> ovf);

    assert_ptr_inside_list_R4: assert property (@(posedge clk) disable iff (rst)
        (st == LD_SCAN) |-> (CW'(ptr) < cnt));

    assert_open_clears_count_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_we && st == LD_ARM2 && mode_val == MODE_OPEN) |=> (cnt == '0 && !ovf));

endmodule

// File: rtl/scanq_conv.sv
module scanq_conv (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic running,
    input  logic done,
    input  logic clr_err,
    output logic step,
    output logic start,
    output logic busy,
    output logic ospeed,
    output logic burst
);
    assign step = trig && running && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            start  <= 1'b0;
            busy   <= 1'b0;
            ospeed <= 1'b0;
            burst  <= 1'b0;
        end else begin
            start <= step;
            if (step)      busy <= 1'b1;
            else if (done) busy <= 1'b0;

            if (trig && running && busy) ospeed <= 1'b1;
            else if (clr_err)            ospeed <= 1'b0;

            if (trig && !running)        burst <= 1'b1;
            else if (clr_err)            burst <= 1'b0;
        end
    end

    assert_busy_blocks_start_R9: assert property (@(posedge clk) disable iff (rst)
        (trig && busy) |=> !start);

    assert_start_follows_trigger_R3: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(trig));

    assert_idle_trigger_flagged_R10: assert property (@(posedge clk) disable iff (rst)
        (trig && !running) |=> burst);

endmodule

// File: rtl/scanq_fifo.sv
module scanq_fifo #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned W     = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         full,
    output logic                         half,
    output logic                         empty,
    output logic                         ovr
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign half    = (cnt >= CW'(DEPTH / 2));
    assign empty   = (cnt == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !clr)
            mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovr <= 1'b0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
            if (push && !do_push) ovr <= 1'b1;
        end
    end

    assert_reset_write_empties_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (empty && !ovr));

    assert_drop_sets_overrun_R8: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && full && !clr) |=> ovr);

    assert_count_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/scanq_top.sv
module scanq_top
    import scanq_pkg::*;
#(
    parameter int unsigned LIST_DEPTH = 256,
    parameter int unsigned FIFO_DEPTH = 1024,
    parameter int unsigned DATA_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [SQ_WORD_W-1:0] wr_data,
    input  logic                 conv_trig,
    input  logic                 adc_done,
    input  logic [DATA_W-1:0]    adc_data,
    input  logic                 fifo_rd,
    output logic [DATA_W-1:0]    fifo_q,
    output logic [SQ_STAT_W-1:0] status,
    output logic                 fe_start,
    output logic [SQ_CHAN_W-1:0] fe_chan,
    output logic [SQ_RNG_W-1:0]  fe_range,
    output logic                 fe_sh,
    output logic                 fe_unipolar,
    output logic                 fe_diff
);
    reg_addr_e addr;
    logic      we_ctrl, we_mode, we_list, we_clr;
    entry_t    cur, fe_ent;
    logic      running, list_ovf;
    logic      step, busy, ospeed, burst;
    logic      f_full, f_half, f_empty, f_ovr;
    logic      uni_q, diff_q;

    assign addr    = reg_addr_e'(wr_addr);
    assign we_ctrl = wr_en && addr == ADDR_CTRL;
    assign we_mode = wr_en && addr == ADDR_MODE;
    assign we_list = wr_en && addr == ADDR_LIST;
    assign we_clr  = wr_en && addr == ADDR_FIFO_CLR;

    always_ff @(posedge clk) begin
        if (rst) begin
            uni_q  <= 1'b0;
            diff_q <= 1'b0;
        end else if (we_ctrl) begin
            uni_q  <= wr_data[CTRL_UNI_BIT];
            diff_q <= wr_data[CTRL_DIFF_BIT];
        end
    end

    scanq_list #(.DEPTH(LIST_DEPTH)) u_list (
        .clk      (clk),
        .rst      (rst),
        .mode_we  (we_mode),
        .mode_val (wr_data),
        .list_we  (we_list),
        .list_ent (unpack_entry(wr_data[SQ_SH_BIT:0])),
        .step     (step),
        .cur      (cur),
        .running  (running),
        .ovf      (list_ovf)
    );

    scanq_conv u_conv (
        .clk     (clk),
        .rst     (rst),
        .trig    (conv_trig),
        .running (running),
        .done    (adc_done),
        .clr_err (we_clr),
        .step    (step),
        .start   (fe_start),
        .busy    (busy),
        .ospeed  (ospeed),
        .burst   (burst)
    );

    scanq_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (we_clr),
        .push  (adc_done),
        .din   (adc_data),
        .pop   (fifo_rd),
        .dout  (fifo_q),
        .full  (f_full),
        .half  (f_half),
        .empty (f_empty),
        .ovr   (f_ovr)
    );

    always_ff @(posedge clk) begin
        if (rst)       fe_ent <= '0;
        else if (step) fe_ent <= cur;
    end

    assign fe_chan     = fe_ent.chan;
    assign fe_range    = fe_ent.rng;
    assign fe_sh       = fe_ent.sh;
    assign fe_unipolar = uni_q;
    assign fe_diff     = diff_q;

    always_comb begin
        status              = '0;
        status[ST_LIST_OVF] = list_ovf;
        status[ST_NFULL]    = !f_full;
        status[ST_NHALF]    = !f_half;
        status[ST_NEMPTY]   = !f_empty;
        status[ST_BURST]    = burst;
        status[ST_OSPEED]   = ospeed;
        status[ST_OVERRUN]  = f_ovr;
        status[ST_READY]    = !busy;
    end

    assert_entry_stable_between_starts_R3: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(fe_ent));

    assert_ready_low_after_start_R9: assert property (@(posedge clk) disable iff (rst)
        (fe_start && !adc_done) |-> !status[ST_READY]);

endmodule

// File: tb/scanq_top_test.sv
`timescale 1ns/1ps
module scanq_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        conv_trig = 1'b0;
    logic        adc_done = 1'b0;
    logic [15:0] adc_data = 16'd0;
    logic        fifo_rd = 1'b0;
    logic [15:0] fifo_q;
    logic [9:0]  status;
    logic        fe_start;
    logic [7:0]  fe_chan;
    logic [1:0]  fe_range;
    logic        fe_sh;
    logic        fe_unipolar;
    logic        fe_diff;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    scanq_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .conv_trig(conv_trig), .adc_done(adc_done), .adc_data(adc_data),
        .fifo_rd(fifo_rd), .fifo_q(fifo_q), .status(status), .fe_start(fe_start),
        .fe_chan(fe_chan), .fe_range(fe_range), .fe_sh(fe_sh),
        .fe_unipolar(fe_unipolar), .fe_diff(fe_diff)
    );

    // list words: channel bits 7:0, range bits 9:8, sample/hold bit 10
    localparam int NV = 5;
    localparam logic [15:0] TBL [NV] = '{16'h0005, 16'h0412, 16'h0237, 16'h0780, 16'h01FF};

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic trig_once;
        @(negedge clk); conv_trig = 1'b1;
        @(negedge clk); conv_trig = 1'b0;
    endtask

    task automatic result(input logic [15:0] d);
        @(negedge clk); adc_done = 1'b1; adc_data = d;
        @(negedge clk); adc_done = 1'b0;
    endtask

    task automatic pop_one;
        @(negedge clk); fifo_rd = 1'b1;
        @(negedge clk); fifo_rd = 1'b0;
    endtask

    task automatic open_list;
        wr(2'd1, 16'd2); wr(2'd1, 16'd0); wr(2'd1, 16'd1);
    endtask

    task automatic chk_entry(input string req, input logic [15:0] w);
        chk(req, "fe_start", 32'(fe_start), 32'd1);
        chk(req, "fe_chan", 32'(fe_chan), 32'(w[7:0]));
        chk(req, "fe_range", 32'(fe_range), 32'(w[9:8]));
        chk(req, "fe_sh", 32'(fe_sh), 32'(w[10]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "status", 32'(status), 32'h181);
        chk("R1", "fe_start", 32'(fe_start), 32'd0);

        // R11 whole-list mode bits
        wr(2'd0, 16'h00C0);
        chk("R11", "fe_unipolar", 32'(fe_unipolar), 32'd1);
        chk("R11", "fe_diff", 32'(fe_diff), 32'd1);
        wr(2'd0, 16'h0040);
        chk("R11", "fe_unipolar", 32'(fe_unipolar), 32'd0);
        chk("R11", "fe_diff", 32'(fe_diff), 32'd1);

        // R10 trigger with no list
        trig_once;
        chk("R10", "fe_start", 32'(fe_start), 32'd0);
        chk("R10", "status", 32'(status), 32'h189);
        wr(2'd3, 16'hABCD);
        chk("R8", "status after reset write", 32'(status), 32'h181);

        // R2 writes outside an open list are ignored; bad handshake
        wr(2'd2, 16'h0063);
        wr(2'd1, 16'd2); wr(2'd1, 16'd1);
        wr(2'd2, 16'h0063);
        wr(2'd1, 16'd0);
        trig_once;
        chk("R2", "fe_start not running", 32'(fe_start), 32'd0);
        chk("R2", "burst bit", 32'(status[3]), 32'd1);
        wr(2'd3, 16'h0000);

        // R3 R4 table-driven scan with wrap
        open_list;
        for (int i = 0; i < NV; i++) wr(2'd2, TBL[i]);
        wr(2'd1, 16'd0);
        for (int i = 0; i < 12; i++) begin
            trig_once;
            chk_entry(i < NV ? "R3" : "R4", TBL[i % NV]);
            chk("R9", "ready low while busy", 32'(status[0]), 32'd0);
            result(16'h1000 + 16'(i));
        end

        // R9 over-speed: second trigger ignored, list not advanced
        trig_once;
        chk_entry("R9", TBL[12 % NV]);
        trig_once;
        chk("R9", "fe_start on busy trigger", 32'(fe_start), 32'd0);
        chk("R9", "status over-speed", 32'(status & 10'h005), 32'h004);
        result(16'h2000);
        trig_once;
        chk_entry("R9", TBL[13 % NV]);
        result(16'h2001);

        // R6 order of results
        for (int i = 0; i < 12; i++) begin
            chk("R6", "fifo_q", 32'(fifo_q), 32'(16'h1000 + 16'(i)));
            pop_one;
        end
        chk("R6", "fifo_q after pops", 32'(fifo_q), 32'h2000);

        wr(2'd3, 16'h5A5A);
        chk("R8", "empty and clear", 32'(status), 32'h181);

        // R7 thresholds and R8 overrun
        for (int i = 0; i < 1024; i++) begin
            result(16'(i));
            if (i == 510) chk("R7", "half not yet", 32'(status[8:6]), 32'b111);
            if (i == 511) chk("R7", "half", 32'(status[8:6]), 32'b101);
            if (i == 1022) chk("R7", "not full", 32'(status[8]), 32'd1);
        end
        chk("R7", "full", 32'(status[8:6]), 32'b001);
        result(16'hEEEE);
        chk("R8", "overrun bit", 32'(status[1]), 32'd1);
        chk("R8", "head", 32'(fifo_q), 32'd0);
        for (int i = 0; i < 1023; i++) pop_one;
        chk("R8", "last kept", 32'(fifo_q), 32'd1023);
        pop_one;
        chk("R7", "empty", 32'(status[6]), 32'd0);
        wr(2'd3, 16'h0001);
        chk("R8", "overrun cleared", 32'(status), 32'h181);

        // R5 full list, extra write dropped, wrap at depth
        open_list;
        for (int i = 0; i < 256; i++) wr(2'd2, 16'(i) | (16'(i % 4) << 8));
        chk("R5", "no overflow yet", 32'(status[9]), 32'd0);
        wr(2'd2, 16'h07AA);
        chk("R5", "overflow bit", 32'(status[9]), 32'd1);
        wr(2'd1, 16'd0);
        for (int k = 0; k < 257; k++) begin
            trig_once;
            chk_entry("R5", 16'(k % 256) | (16'((k % 256) % 4) << 8));
            result(16'(k));
        end
        wr(2'd3, 16'h0000);
        open_list;
        chk("R5", "overflow cleared on open", 32'(status[9]), 32'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule